// File: doc/BRIEF.md
# Link Security Status Register

This block holds the 8-bit read-only status word that a serial video link transmitter offers to its host controller about content-protection authentication and the state of the downstream link. It turns single-cycle event strobes from the authentication engine and the downstream link monitor into status bits. It samples three downstream level lines. It returns the word when the controller reads the block's address.

Each bit follows one clearing rule. Two bits are sticky and clear when the register is read. Three bits are registered copies of level lines. Two bits are handshake bits that stall the authentication engine until the controller writes a validation flag into its control register. The last bit reports authentication success and drops when authentication is lost or restarted. A read of any other address returns zero and does not disturb the word.

Top module: `lss_status_reg`

## Requirements
- R1: The register answers at address 0xC4 and resets to 0x00. While `rd_en` is high and `rd_addr` is 0xC4, `rd_data` shows the current status word in the same cycle. An asserted `rst_n` clears the word at once.
- R2: Bit 7 is set one cycle after `ev_chan_err` pulses. It stays set until a read of 0xC4.
- R3: Bit 6 holds the value that `rx_irq_n` had at the previous clock edge. The line is active low, so a 0 means the downstream receiver has an interrupt pending.
- R4: Bit 5 holds the value of `rx_locked` from the previous edge. Bit 3 holds the value of `rx_present` from the previous edge.
- R5: Bit 4 is set one cycle after `ev_hotplug` pulses. It stays set until a read of 0xC4.
- R6: A read of 0xC4 returns the value held before the read and then clears bits 7 and 4. An event pulse on either of these bits in the same cycle as the read keeps that bit set.
- R7: A read with any address other than 0xC4 returns 0x00 and leaves every bit unchanged.
- R8: Bit 2 is set by `ev_list_ready`. While it is set, `stall_list` is high. It clears after a cycle with both `ctl_wr` and `ctl_list_ok` high. A new `ev_list_ready` in that same cycle keeps the bit set.
- R9: Bit 1 is set by `ev_key_ready`. It clears after a cycle with both `ctl_wr` and `ctl_key_ok` high, or after a cycle with `ev_auth_fail` high. A new `ev_key_ready` in that same cycle keeps the bit set. `stall_key` is high only while bit 1 is set and `dn_repeater` is low.
- R10: Bit 0 is set by `ev_auth_pass`. It clears after `ev_auth_drop`, or after a cycle with both `ctl_wr` and `ctl_restart` high. When a clear and `ev_auth_pass` fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Status word when the read hits, zero otherwise |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_list_ok | input | 1 | Written flag that accepts the repeater key list |
| ctl_key_ok | input | 1 | Written flag that accepts the receiver key |
| ctl_restart | input | 1 | Written flag that restarts authentication |
| ev_chan_err | input | 1 | Pulse: error on the embedded control channel |
| ev_hotplug | input | 1 | Pulse: hot-plug report of a new receiver |
| ev_list_ready | input | 1 | Pulse: repeater key list loaded |
| ev_key_ready | input | 1 | Pulse: receiver key available |
| ev_auth_pass | input | 1 | Pulse: authentication succeeded |
| ev_auth_fail | input | 1 | Pulse: authentication failed |
| ev_auth_drop | input | 1 | Pulse: authentication lost |
| rx_irq_n | input | 1 | Downstream interrupt line, active low |
| rx_locked | input | 1 | Downstream receiver locked to serial data |
| rx_present | input | 1 | Downstream receiver detected |
| dn_repeater | input | 1 | Downstream device is a repeater |
| stall_list | output | 1 | Holds the engine until the key list is accepted |
| stall_key | output | 1 | Holds the engine until the key is accepted (non-repeater only) |

## Verification
The two functions most likely to meet in one cycle are a new event that sets a bit and a clear of that same bit. The clear can come from a read of the register, from a control write, or from an authentication failure or loss. The bench drives the setting pulse in the very cycle of the clear. It then checks two things: that the read in that cycle returns the old value, and that a read one cycle later shows the bit still set for the sticky and handshake bits and cleared for the authentication bit.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int unsigned STAT_W      = 8;
  localparam int unsigned LVL_W       = 3;
  // Bit positions of the status word (decoded by host software)
  localparam int unsigned BIT_AUTH    = 0;
  localparam int unsigned BIT_KEY     = 1;
  localparam int unsigned BIT_LIST    = 2;
  localparam int unsigned BIT_PRESENT = 3;
  localparam int unsigned BIT_PLUG    = 4;
  localparam int unsigned BIT_LOCK    = 5;
  localparam int unsigned BIT_IRQ     = 6;
  localparam int unsigned BIT_ERR     = 7;
  // Index of each level line inside the captured level vector
  localparam int unsigned LVL_PRESENT = 0;
  localparam int unsigned LVL_LOCK    = 1;
  localparam int unsigned LVL_IRQ     = 2;
endpackage

// File: rtl/lss_rst_sync.sv
module lss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/lss_flag_cell.sv
// One status flag with a set and a clear request. SET_WINS picks
// which request prevails when both arrive in the same cycle.
module lss_flag_cell #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    if (SET_WINS) q_d = set_i;
    else          q_d = set_i & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/lss_level_cap.sv
// Registers a group of level lines, one flop per line.
module lss_level_cap #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] lvl_q
);
  for (genvar g = 0; g < W; g++) begin : g_cap
    logic nxt;
    always_comb nxt = lvl_i[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= nxt;
    end
  end
endmodule

// File: rtl/lss_read_port.sv
module lss_read_port #(
  parameter int unsigned          ADDR_W   = 8,
  parameter int unsigned          DATA_W   = 8,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 8'hC4
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] stat_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    hit_o  = rd_en && (rd_addr == REG_ADDR);
    data_o = hit_o ? stat_i : '0;
  end
endmodule

// File: rtl/lss_status_reg.sv
module lss_status_reg
  import lss_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'hC4,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STAT_W-1:0] rd_data,
  input  logic              ctl_wr,
  input  logic              ctl_list_ok,
  input  logic              ctl_key_ok,
  input  logic              ctl_restart,
  input  logic              ev_chan_err,
  input  logic              ev_hotplug,
  input  logic              ev_list_ready,
  input  logic              ev_key_ready,
  input  logic              ev_auth_pass,
  input  logic              ev_auth_fail,
  input  logic              ev_auth_drop,
  input  logic              rx_irq_n,
  input  logic              rx_locked,
  input  logic              rx_present,
  input  logic              dn_repeater,
  output logic              stall_list,
  output logic              stall_key
);
  logic              rst_q_n;
  logic              rd_hit;
  logic [STAT_W-1:0] stat_q;
  logic [LVL_W-1:0]  lvl_in;
  logic [LVL_W-1:0]  lvl_q;
  logic              list_clr, key_clr, auth_clr;

  lss_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  lss_read_port #(.ADDR_W(ADDR_W), .DATA_W(STAT_W), .REG_ADDR(REG_ADDR)) rdp_i (
    .rd_en(rd_en), .rd_addr(rd_addr), .stat_i(stat_q),
    .hit_o(rd_hit), .data_o(rd_data)
  );

  always_comb begin
    lvl_in              = '0;
    lvl_in[LVL_PRESENT] = rx_present;
    lvl_in[LVL_LOCK]    = rx_locked;
    lvl_in[LVL_IRQ]     = rx_irq_n;
    list_clr = ctl_wr & ctl_list_ok;
    key_clr  = (ctl_wr & ctl_key_ok) | ev_auth_fail;
    auth_clr = ev_auth_drop | (ctl_wr & ctl_restart);
  end

  lss_level_cap #(.W(LVL_W)) lvl_i (
    .clk(clk), .rst_n(rst_q_n), .lvl_i(lvl_in), .lvl_q(lvl_q)
  );

  assign stat_q[BIT_IRQ]     = lvl_q[LVL_IRQ];
  assign stat_q[BIT_LOCK]    = lvl_q[LVL_LOCK];
  assign stat_q[BIT_PRESENT] = lvl_q[LVL_PRESENT];

  lss_flag_cell #(.SET_WINS(1'b1)) err_i (
    .clk(clk), .rst_n(rst_q_n), .set_i(ev_chan_err), .clr_i(rd_hit),
    .q_o(stat_q[BIT_ERR])
  );
  lss_flag_cell #(.SET_WINS(1'b1)) plug_i (
    .clk(clk), .rst_n(rst_q_n), .set_i(ev_hotplug), .clr_i(rd_hit),
    .q_o(stat_q[BIT_PLUG])
  );
  lss_flag_cell #(.SET_WINS(1'b1)) list_i (
    .clk(clk), .rst_n(rst_q_n), .set_i(ev_list_ready), .clr_i(list_clr),
    .q_o(stat_q[BIT_LIST])
  );
  lss_flag_cell #(.SET_WINS(1'b1)) key_i (
    .clk(clk), .rst_n(rst_q_n), .set_i(ev_key_ready), .clr_i(key_clr),
    .q_o(stat_q[BIT_KEY])
  );
  lss_flag_cell #(.SET_WINS(1'b0)) auth_i (
    .clk(clk), .rst_n(rst_q_n), .set_i(ev_auth_pass), .clr_i(auth_clr),
    .q_o(stat_q[BIT_AUTH])
  );

  always_comb begin
    stall_list = stat_q[BIT_LIST];
    stall_key  = stat_q[BIT_KEY] & ~dn_repeater;
  end
endmodule

// File: rtl/lss_status_chk.sv
module lss_status_chk #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC4
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              rd_hit,
  input logic [7:0]        stat_q,
  input logic              ev_chan_err,
  input logic              ev_list_ready,
  input logic              ev_key_ready,
  input logic              ev_auth_fail,
  input logic              ev_auth_drop,
  input logic              ctl_wr,
  input logic              ctl_list_ok,
  input logic              rx_irq_n,
  input logic              rx_locked,
  input logic              rx_present,
  input logic              dn_repeater,
  input logic              stall_list,
  input logic              stall_key
);
  // R2
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ev_chan_err |=> stat_q[7]);
  // R6
  err_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_hit && !ev_chan_err) |=> !stat_q[7]);
  // R7
  miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!rd_hit && stat_q[4]) |=> stat_q[4]);
  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && rd_addr != REG_ADDR) |-> rd_data == 8'h00);
  // R3
  irq_copy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> stat_q[6] == $past(rx_irq_n));
  // R4
  lock_copy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> stat_q[5] == $past(rx_locked));
  // R4
  present_copy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> stat_q[3] == $past(rx_present));
  // R8
  list_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ev_list_ready |=> stat_q[2] && stall_list);
  // R8
  list_release_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_wr && ctl_list_ok && !ev_list_ready) |=> !stall_list);
  // R9
  key_fail_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ev_auth_fail && !ev_key_ready) |=> !stat_q[1]);
  // R9
  rep_nostall_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    dn_repeater |-> !stall_key);
  // R10
  auth_drop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ev_auth_drop |=> !stat_q[0]);
endmodule

bind lss_status_reg lss_status_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) chk_i (
  .clk(clk), .rst_q_n(rst_q_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .rd_hit(rd_hit), .stat_q(stat_q),
  .ev_chan_err(ev_chan_err), .ev_list_ready(ev_list_ready),
  .ev_key_ready(ev_key_ready), .ev_auth_fail(ev_auth_fail),
  .ev_auth_drop(ev_auth_drop), .ctl_wr(ctl_wr), .ctl_list_ok(ctl_list_ok),
  .rx_irq_n(rx_irq_n), .rx_locked(rx_locked), .rx_present(rx_present),
  .dn_repeater(dn_repeater), .stall_list(stall_list), .stall_key(stall_key)
);

// File: tb/lss_status_reg_tb.sv
`timescale 1ns/1ps
module lss_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       ctl_wr, ctl_list_ok, ctl_key_ok, ctl_restart;
  logic       ev_chan_err, ev_hotplug, ev_list_ready, ev_key_ready;
  logic       ev_auth_pass, ev_auth_fail, ev_auth_drop;
  logic       rx_irq_n, rx_locked, rx_present, dn_repeater;
  logic       stall_list, stall_key;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  lss_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctl_wr(ctl_wr), .ctl_list_ok(ctl_list_ok), .ctl_key_ok(ctl_key_ok),
    .ctl_restart(ctl_restart), .ev_chan_err(ev_chan_err), .ev_hotplug(ev_hotplug),
    .ev_list_ready(ev_list_ready), .ev_key_ready(ev_key_ready),
    .ev_auth_pass(ev_auth_pass), .ev_auth_fail(ev_auth_fail),
    .ev_auth_drop(ev_auth_drop), .rx_irq_n(rx_irq_n), .rx_locked(rx_locked),
    .rx_present(rx_present), .dn_repeater(dn_repeater),
    .stall_list(stall_list), .stall_key(stall_key)
  );

  // Vector: ev[6:0] = {drop,fail,pass,key,list,hotplug,err}
  //         lvl[2:0] = {irq_n,locked,present}, rep
  //         ctl[3:0] = {restart,key_ok,list_ok,wr}, rd, addr
  //         expected rd_data in this cycle, expected {stall_list,stall_key}, req
  localparam int NVEC = 31;
  localparam logic [37:0] VEC [NVEC] = '{
    {7'h00,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h00,2'b00,4'd1},  // R1 reset value
    {7'h01,3'h4,1'b0,4'h0,1'b0,8'h00,8'h00,2'b00,4'd2},  // R2 error pulse
    {7'h00,3'h4,1'b0,4'h0,1'b1,8'hC4,8'hC0,2'b00,4'd2},  // R2 R3 read
    {7'h00,3'h4,1'b0,4'h0,1'b1,8'hC4,8'h40,2'b00,4'd3},  // R3 err cleared, irq kept
    {7'h02,3'h7,1'b0,4'h0,1'b0,8'h00,8'h00,2'b00,4'd5},  // R5 hot-plug pulse
    {7'h00,3'h7,1'b0,4'h0,1'b1,8'hC3,8'h00,2'b00,4'd7},  // R7 miss reads zero
    {7'h02,3'h7,1'b0,4'h0,1'b1,8'hC4,8'h78,2'b00,4'd6},  // R6 set with read
    {7'h00,3'h7,1'b0,4'h0,1'b1,8'hC4,8'h78,2'b00,4'd6},  // R6 bit 4 survived
    {7'h00,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h68,2'b00,4'd4},  // R4 levels, bit 4 cleared
    {7'h04,3'h0,1'b1,4'h0,1'b0,8'h00,8'h00,2'b00,4'd8},  // R8 list loaded
    {7'h00,3'h0,1'b1,4'h0,1'b1,8'hC4,8'h04,2'b10,4'd8},  // R8 stalled
    {7'h00,3'h0,1'b1,4'h5,1'b0,8'h00,8'h00,2'b10,4'd8},  // R8 wrong flag written
    {7'h00,3'h0,1'b1,4'h3,1'b1,8'hC4,8'h04,2'b10,4'd8},  // R8 list accepted
    {7'h00,3'h0,1'b1,4'h0,1'b1,8'hC4,8'h00,2'b00,4'd8},  // R8 released
    {7'h08,3'h0,1'b0,4'h0,1'b0,8'h00,8'h00,2'b00,4'd9},  // R9 key ready
    {7'h00,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h02,2'b01,4'd9},  // R9 non-repeater stall
    {7'h00,3'h0,1'b1,4'h0,1'b1,8'hC4,8'h02,2'b00,4'd9},  // R9 repeater no stall
    {7'h20,3'h0,1'b0,4'h0,1'b0,8'h00,8'h00,2'b01,4'd9},  // R9 auth failure
    {7'h08,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h00,2'b00,4'd9},  // R9 cleared, key again
    {7'h00,3'h0,1'b0,4'h5,1'b1,8'hC4,8'h02,2'b01,4'd9},  // R9 key accepted
    {7'h10,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h00,2'b00,4'd10}, // R10 auth pass
    {7'h00,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h01,2'b00,4'd10}, // R10 authenticated
    {7'h00,3'h0,1'b0,4'h9,1'b1,8'hC4,8'h01,2'b00,4'd10}, // R10 restart write
    {7'h10,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h00,2'b00,4'd10}, // R10 restarted, pass
    {7'h40,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h01,2'b00,4'd10}, // R10 auth lost
    {7'h50,3'h0,1'b0,4'h0,1'b1,8'hC4,8'h00,2'b00,4'd10}, // R10 pass with loss
    {7'h00,3'h0,1'b1,4'h0,1'b1,8'hC4,8'h00,2'b00,4'd10}, // R10 clear won
    {7'h04,3'h0,1'b1,4'h3,1'b1,8'hC4,8'h00,2'b00,4'd8},  // R8 load with accept
    {7'h00,3'h0,1'b1,4'h0,1'b1,8'hC4,8'h04,2'b10,4'd8},  // R8 load won
    {7'h00,3'h0,1'b1,4'h3,1'b0,8'h00,8'h00,2'b10,4'd8},  // R8 accept
    {7'h00,3'h0,1'b1,4'h0,1'b1,8'hC4,8'h00,2'b00,4'd8}   // R8 released
  };

  task automatic check(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %02h expected %02h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    {ev_chan_err, ev_hotplug, ev_list_ready, ev_key_ready} = '0;
    {ev_auth_pass, ev_auth_fail, ev_auth_drop} = '0;
    {ctl_wr, ctl_list_ok, ctl_key_ok, ctl_restart} = '0;
    rd_en = 1'b0; rd_addr = 8'h00;
  endtask

  task automatic apply(input logic [37:0] v);
    logic [6:0] ev; logic [2:0] lvl; logic [3:0] ctl;
    ev  = v[37:31]; lvl = v[30:28]; ctl = v[26:23];
    {ev_auth_drop, ev_auth_fail, ev_auth_pass, ev_key_ready,
     ev_list_ready, ev_hotplug, ev_chan_err} = ev;
    {rx_irq_n, rx_locked, rx_present} = lvl;
    dn_repeater = v[27];
    {ctl_restart, ctl_key_ok, ctl_list_ok, ctl_wr} = ctl;
    rd_en = v[22]; rd_addr = v[21:14];
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    {rx_irq_n, rx_locked, rx_present, dn_repeater} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #1;
      check(int'(VEC[i][3:0]), $sformatf("vec %0d data", i), rd_data, VEC[i][13:6]);
      check(int'(VEC[i][3:0]), $sformatf("vec %0d stall", i),
            {6'd0, stall_list, stall_key}, {6'd0, VEC[i][5:4]});
    end

    // R1 directed: reset in the middle of activity clears the word at once
    @(negedge clk);
    idle(); ev_chan_err = 1'b1; ev_list_ready = 1'b1; ev_auth_pass = 1'b1;
    @(negedge clk);
    idle(); rd_en = 1'b1; rd_addr = 8'hC4;
    #1 check(1, "pre-reset word", rd_data, 8'h85);
    rst_n = 1'b0;
    #0.5 check(1, "word under reset", rd_data, 8'h00);
    check(1, "stall under reset", {6'd0, stall_list, stall_key}, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1 check(1, "word after reset", rd_data, 8'h00);

    // R7 directed: a control-free miss read next to a hit leaves the error bit
    idle(); ev_chan_err = 1'b1;
    @(negedge clk);
    idle(); rd_en = 1'b1; rd_addr = 8'h44;
    #1 check(7, "miss read data", rd_data, 8'h00);
    @(negedge clk);
    rd_addr = 8'hC4;
    #1 check(7, "bit 7 kept by miss", rd_data, 8'h80);
    @(negedge clk);
    #1 check(2, "bit 7 cleared by hit", rd_data, 8'h00);
    @(negedge clk) idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule